// File: doc/BRIEF.md
# Four-Channel Programmable Timer Bank

The block holds four identical 16-bit up-counting timers behind one small register port. Software reaches every timer through a single-cycle read strobe and write strobe. Each timer owns a window of the address space. Inside its window it keeps a running count, a mode word, a compare value and, on the first two timers only, a hold value. A periodic tick input paces all four timers together. On a tick, each timer whose count enable is set advances its count by one.

A timer whose compare-enable or overflow-enable mode bit is set fires on every tick. Firing raises a one-clock pulse on that timer's interrupt line. If the zero-return bit is also set, firing sends the count back to zero. Timer 0 stays armed, so it fires periodically. Timers 1 to 3 are single-shot: when they fire, they drop their compare-enable bit and their overflow-flag bit.

Mode bit positions:

| Bit | Meaning |
|---|---|
| 6 | zero-return |
| 7 | count enable |
| 8 | compare-enable |
| 9 | overflow-enable |
| 10 | compare flag |
| 11 | overflow flag |

Top module: `tmr_bank`

## Requirements
- R1: While reset is high, and on the first cycle after it, every count, mode, compare and hold register reads zero and all interrupt lines are low.
- R2: Address bits [12:11] select the timer. Within a window, the low 11 bits select the register: count at 0x00, mode at 0x10, compare at 0x20, hold at 0x30. A write is visible to a read of the same register on the next cycle. The mode register keeps only bits [11:0], and its upper read bits are zero.
- R3: On a tick, a timer whose mode bit 7 is set increments its count by exactly one. When bit 7 is clear, or no tick occurs, the count holds.
- R4: A count of 0xFFFF that increments becomes 0x0000.
- R5: A tick while mode bit 8 or bit 9 is set drives interrupt line i high for exactly the next clock cycle. With neither bit set, or without a tick, line i stays low.
- R6: When a timer fires with mode bit 6 set, its count reads 0 after that tick, whatever the increment. Bit 6 has no effect when the timer does not fire.
- R7: After firing, timers 1 to 3 clear mode bits 8 and 11 and keep all other mode bits, so bit 9 stays set if it was set. Timer 0 keeps its whole mode word.
- R8: The hold register exists on timers 0 and 1. A read or write of offset 0x30 on timers 2 or 3 raises the combinational `hold_bad_o` in that same cycle. Such a read returns 0, and such a write changes nothing.
- R9: Reads of any other offset return 0, and writes to any other offset change no register.
- R10: A software write to a count or mode register in the same cycle as a tick takes priority over the tick's update of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous active-high reset |
| tick_i | input | 1 | one-cycle timer advance strobe |
| wr_i | input | 1 | register write strobe |
| rd_i | input | 1 | register read strobe |
| addr_i | input | 13 | register byte offset |
| wdata_i | input | 16 | write data |
| rdata_o | output | 16 | read data, valid in the cycle of rd_i, zero otherwise |
| hold_bad_o | output | 1 | access to a missing hold register |
| irq_o | output | 4 | per-timer interrupt pulses |

## Verification
The assertions assume that software never asserts rd_i and wr_i together. They also assume that, when a write lands in the same cycle as a tick, only the written register follows software. For that reason, the stability and disarm checks are qualified by the absence of a write. The stimulus keeps the two strobes exclusive. It deliberately combines ticks with writes, both in a directed same-cycle test and in a pseudo-random phase. A behavioural model mirrors every register and is compared with the interrupt lines and the read data on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MODE_W  = 12;
  localparam int MB_ZRET = 6;
  localparam int MB_CUE  = 7;
  localparam int MB_CMPE = 8;
  localparam int MB_OVFE = 9;
  localparam int MB_CMPF = 10;
  localparam int MB_OVFF = 11;

  typedef enum logic [2:0] {
    RK_COUNT,
    RK_MODE,
    RK_COMP,
    RK_HOLD,
    RK_NONE
  } reg_kind_e;

  // Fires on a tick when either interrupt enable is armed.
  function automatic logic arms(input logic [MODE_W-1:0] m);
    return m[MB_CMPE] | m[MB_OVFE];
  endfunction

  // Single-shot timers drop compare enable and overflow flag after firing.
  function automatic logic [MODE_W-1:0] disarm(input logic [MODE_W-1:0] m);
    logic [MODE_W-1:0] r;
    r = m;
    r[MB_CMPE] = 1'b0;
    r[MB_OVFF] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int N_TMR     = 4,
  parameter int SEL_SHIFT = 11,
  parameter int HOLD_TMRS = 2,
  localparam int IDX_W    = $clog2(N_TMR),
  localparam int ADDR_W   = SEL_SHIFT + IDX_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [IDX_W-1:0]    idx_o,
  output tmr_pkg::reg_kind_e  kind_o,
  output logic                hold_miss_o
);
  import tmr_pkg::*;

  localparam logic [SEL_SHIFT-1:0] OFF_CNT  = SEL_SHIFT'(8'h00);
  localparam logic [SEL_SHIFT-1:0] OFF_MODE = SEL_SHIFT'(8'h10);
  localparam logic [SEL_SHIFT-1:0] OFF_COMP = SEL_SHIFT'(8'h20);
  localparam logic [SEL_SHIFT-1:0] OFF_HOLD = SEL_SHIFT'(8'h30);

  logic [SEL_SHIFT-1:0] off;

  assign off   = addr_i[SEL_SHIFT-1:0];
  assign idx_o = addr_i[SEL_SHIFT +: IDX_W];

  always_comb begin
    kind_o      = RK_NONE;
    hold_miss_o = 1'b0;
    if (off == OFF_CNT) begin
      kind_o = RK_COUNT;
    end else if (off == OFF_MODE) begin
      kind_o = RK_MODE;
    end else if (off == OFF_COMP) begin
      kind_o = RK_COMP;
    end else if (off == OFF_HOLD) begin
      if (32'(idx_o) < HOLD_TMRS) kind_o = RK_HOLD;
      else                        hold_miss_o = 1'b1;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CNT_W    = 16,
  parameter bit HAS_HOLD = 1'b1,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        tick_i,
  input  logic                        wr_en_i,
  input  tmr_pkg::reg_kind_e          kind_i,
  input  logic [CNT_W-1:0]            wdata_i,
  output logic [CNT_W-1:0]            rdata_o,
  output logic                        fire_o,
  output logic                        irq_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [tmr_pkg::MODE_W-1:0]  mode_o
);
  import tmr_pkg::*;

  logic [CNT_W-1:0]  cnt_q, cmp_q, hold_q, cnt_nx;
  logic [MODE_W-1:0] mode_q, mode_nx;
  logic              irq_q;

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c,
                                                input logic [MODE_W-1:0] m,
                                                input logic fire);
    logic [CNT_W-1:0] r;
    r = m[MB_CUE] ? c + CNT_W'(1) : c;
    if (fire && m[MB_ZRET]) r = '0;
    return r;
  endfunction

  assign fire_o = tick_i & arms(mode_q);

  always_comb begin
    cnt_nx  = tick_i ? step_cnt(cnt_q, mode_q, fire_o) : cnt_q;
    mode_nx = (fire_o && ONE_SHOT) ? disarm(mode_q) : mode_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      mode_q <= '0;
      cmp_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= fire_o;
      cnt_q  <= (wr_en_i && kind_i == RK_COUNT) ? wdata_i : cnt_nx;
      mode_q <= (wr_en_i && kind_i == RK_MODE) ? wdata_i[MODE_W-1:0] : mode_nx;
      if (wr_en_i && kind_i == RK_COMP) cmp_q <= wdata_i;
    end
  end

  generate
    if (HAS_HOLD) begin : g_hold
      always_ff @(posedge clk_i) begin
        if (rst_i)                                hold_q <= '0;
        else if (wr_en_i && kind_i == RK_HOLD)    hold_q <= wdata_i;
      end
    end else begin : g_nohold
      assign hold_q = '0;
    end
  endgenerate

  always_comb begin
    case (kind_i)
      RK_COUNT: rdata_o = cnt_q;
      RK_MODE:  rdata_o = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      RK_COMP:  rdata_o = cmp_q;
      RK_HOLD:  rdata_o = hold_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o  = irq_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int N_TMR     = 4,
  parameter int CNT_W     = 16,
  parameter int SEL_SHIFT = 11,
  parameter int HOLD_TMRS = 2,
  parameter int SHOT_FROM = 1,
  localparam int IDX_W    = $clog2(N_TMR),
  localparam int ADDR_W   = SEL_SHIFT + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              hold_bad_o,
  output logic [N_TMR-1:0]  irq_o
);
  import tmr_pkg::*;

  logic [IDX_W-1:0]                  sel_idx;
  reg_kind_e                         sel_kind;
  logic                              hold_miss;
  logic [N_TMR-1:0][CNT_W-1:0]       unit_rd;
  logic [N_TMR-1:0][CNT_W-1:0]       cnt_all;
  logic [N_TMR-1:0][MODE_W-1:0]      mode_all;
  logic [N_TMR-1:0]                  fire_all;

  tmr_decode #(
    .N_TMR(N_TMR), .SEL_SHIFT(SEL_SHIFT), .HOLD_TMRS(HOLD_TMRS)
  ) dec_i (
    .addr_i(addr_i), .idx_o(sel_idx), .kind_o(sel_kind), .hold_miss_o(hold_miss)
  );

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
      tmr_unit #(
        .CNT_W(CNT_W), .HAS_HOLD(i < HOLD_TMRS), .ONE_SHOT(i >= SHOT_FROM)
      ) unit_i (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i),
        .wr_en_i(wr_i && (sel_idx == IDX_W'(i))),
        .kind_i(sel_kind), .wdata_i(wdata_i),
        .rdata_o(unit_rd[i]), .fire_o(fire_all[i]), .irq_o(irq_o[i]),
        .cnt_o(cnt_all[i]), .mode_o(mode_all[i])
      );
    end
  endgenerate

  assign rdata_o    = rd_i ? unit_rd[sel_idx] : '0;
  assign hold_bad_o = (rd_i | wr_i) & hold_miss;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int N_TMR     = 4,
  parameter int CNT_W     = 16,
  parameter int SHOT_FROM = 1
) (
  input logic                                clk_i,
  input logic                                rst_i,
  input logic                                tick_i,
  input logic                                wr_i,
  input logic                                rd_i,
  input logic [CNT_W-1:0]                    rdata_o,
  input logic                                hold_bad_o,
  input logic [N_TMR-1:0]                    irq_o,
  input logic [N_TMR-1:0][CNT_W-1:0]         cnt_all,
  input logic [N_TMR-1:0][tmr_pkg::MODE_W-1:0] mode_all,
  input logic [N_TMR-1:0]                    fire_all
);
  import tmr_pkg::*;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (irq_o == '0 && cnt_all == '0 && mode_all == '0));

  assert_irq_needs_tick_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> irq_o == '0);

  assert_hold_miss_reads_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (hold_bad_o && rd_i) |-> rdata_o == '0);

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
      assert_count_stable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !wr_i) |=> $stable(cnt_all[i]));

      assert_wrap_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !wr_i && mode_all[i][MB_CUE] && !fire_all[i] && cnt_all[i] == '1)
        |=> cnt_all[i] == '0);

      assert_zero_return_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (fire_all[i] && mode_all[i][MB_ZRET] && !wr_i) |=> cnt_all[i] == '0);

      if (i >= SHOT_FROM) begin : g_shot
        assert_disarm_R7: assert property (@(posedge clk_i) disable iff (rst_i)
          (fire_all[i] && !wr_i) |=> (!mode_all[i][MB_CMPE] && !mode_all[i][MB_OVFF]));
      end else begin : g_keep
        assert_keep_mode_R7: assert property (@(posedge clk_i) disable iff (rst_i)
          (fire_all[i] && !wr_i) |=> $stable(mode_all[i]));
      end
    end
  endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR), .CNT_W(CNT_W), .SHOT_FROM(SHOT_FROM)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
  .rdata_o(rdata_o), .hold_bad_o(hold_bad_o), .irq_o(irq_o),
  .cnt_all(cnt_all), .mode_all(mode_all), .fire_all(fire_all)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [12:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        hold_bad;
  logic [3:0]  irq;

  int n_chk = 0, n_bad = 0;
  int m_cnt [4], m_mode [4], m_cmp [4], m_hold [2];
  logic [3:0] m_irq = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tmr_bank dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .hold_bad_o(hold_bad), .irq_o(irq)
  );

  function automatic int A(input int t, input int off);
    return (t << 11) | off;
  endfunction

  function automatic int model_read(input int a);
    int t, off;
    t = (a >> 11) & 3; off = a & 'h7FF;
    case (off)
      'h00: return m_cnt[t];
      'h10: return m_mode[t];
      'h20: return m_cmp[t];
      'h30: return (t < 2) ? m_hold[t] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive, check combinational and registered outputs, advance model.
  task automatic step(input bit tk, input bit w, input bit r, input int a, input int d,
                      input string tag);
    int t, off;
    bit fire;
    @(negedge clk);
    tick = tk; wr = w; rd = r; addr = 13'(a); wdata = 16'(d);
    #1;
    t = (a >> 11) & 3; off = a & 'h7FF;
    check("R5 irq", int'(irq), int'(m_irq));
    check("R8 hold_bad", int'(hold_bad), int'((w || r) && off == 'h30 && t >= 2));
    if (r) check(tag, int'(rdata), model_read(a));
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      fire = tk && ((m_mode[i] & 'h300) != 0);
      m_irq[i] = fire;
      if (tk && (m_mode[i] & 'h80) != 0) m_cnt[i] = (m_cnt[i] + 1) & 'hFFFF;
      if (fire && (m_mode[i] & 'h40) != 0) m_cnt[i] = 0;
      if (fire && i > 0) m_mode[i] = m_mode[i] & ~('h100 | 'h800);
    end
    if (w) begin
      case (off)
        'h00: m_cnt[t] = d & 'hFFFF;
        'h10: m_mode[t] = d & 'hFFF;
        'h20: m_cmp[t] = d & 'hFFFF;
        'h30: if (t < 2) m_hold[t] = d & 'hFFFF;
        default: ;
      endcase
    end
  endtask

  task automatic wreg(input int a, input int d, input string tag);
    step(1'b0, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rreg(input int a, input string tag);
    step(1'b0, 1'b0, 1'b1, a, 0, tag);
  endtask
  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0, 1'b0, 0, 0, "R3");
  endtask
  task automatic read_all(input string tag);
    for (int t = 0; t < 4; t++)
      for (int o = 0; o < 4; o++) rreg(A(t, o * 'h10), tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_mode[i] = 0; m_cmp[i] = 0; end
    m_hold[0] = 0; m_hold[1] = 0;
    repeat (3) @(negedge clk);
    #1; check("R1 irq in reset", int'(irq), 0);
    rst = 1'b0;
    read_all("R1 reset value");

    // R2: readback of every register with distinct data
    for (int t = 0; t < 4; t++) begin
      wreg(A(t, 'h00), 'h1000 + t * 'h111, "R2");
      wreg(A(t, 'h20), 'hC000 + t * 7, "R2");
      wreg(A(t, 'h10), 'hF43F, "R2 mode mask");
      if (t < 2) wreg(A(t, 'h30), 'h5A00 + t, "R2");
    end
    read_all("R2 readback");

    // R8: missing hold on timers 2 and 3
    wreg(A(2, 'h30), 'hBEEF, "R8 write");
    wreg(A(3, 'h30), 'hCAFE, "R8 write");
    rreg(A(2, 'h30), "R8 read zero");
    rreg(A(3, 'h30), "R8 read zero");

    // R9: unmapped offsets
    wreg(A(0, 'h40), 'hFFFF, "R9"); wreg(A(1, 'h08), 'h1111, "R9");
    wreg(A(3, 'h7F0), 'h2222, "R9"); wreg(A(2, 'h14), 'h3333, "R9");
    rreg(A(0, 'h40), "R9 read zero"); rreg(A(3, 'h7F0), "R9 read zero");
    read_all("R9 unchanged");

    // R3/R4: count enable and wrap on timer 0; others idle
    for (int t = 0; t < 4; t++) wreg(A(t, 'h10), 0, "R3");
    ticks(2);
    read_all("R3 no count without enable");
    wreg(A(0, 'h10), 'h080, "R3");
    wreg(A(0, 'h00), 'hFFFD, "R4");
    ticks(5);
    rreg(A(0, 'h00), "R4 wrap");
    check("R4 wrap value", int'(rdata), 'h0002);

    // R5/R6: timer 0 periodic with zero-return
    wreg(A(0, 'h10), 'h1C0, "R6");
    wreg(A(0, 'h00), 'h0050, "R6");
    ticks(3);
    rreg(A(0, 'h00), "R6 zero return");
    check("R6 count zero", int'(rdata), 0);
    rreg(A(0, 'h10), "R7 timer0 keeps mode");
    check("R7 timer0 mode", int'(rdata), 'h1C0);

    // R6: zero-return without enables has no effect
    wreg(A(3, 'h10), 'h0C0, "R6");
    wreg(A(3, 'h00), 'h0007, "R6");
    ticks(2);
    rreg(A(3, 'h00), "R6 no fire");
    check("R6 count kept", int'(rdata), 'h0009);

    // R7: single-shot on timer 1, overflow path on timer 2
    wreg(A(0, 'h10), 0, "R7");
    wreg(A(1, 'h10), 'hD80, "R7");
    wreg(A(2, 'h10), 'hA00, "R7");
    ticks(3);
    rreg(A(1, 'h10), "R7 disarmed");
    check("R7 timer1 mode", int'(rdata), 'h480);
    rreg(A(2, 'h10), "R7 ovfe kept");
    check("R7 timer2 mode", int'(rdata), 'h200);

    // R10: write during tick wins
    wreg(A(1, 'h10), 'h080, "R10");
    step(1'b1, 1'b1, 1'b0, A(1, 'h00), 'h1234, "R10");
    rreg(A(1, 'h00), "R10 write wins");
    check("R10 count", int'(rdata), 'h1234);
    step(1'b1, 1'b1, 1'b0, A(0, 'h10), 'h380, "R10 mode");
    step(1'b1, 1'b1, 1'b0, A(2, 'h10), 'h1C0, "R10 mode");
    rreg(A(2, 'h10), "R10 mode write wins");

    // Mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      int t, o;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = int'(lfsr[3:2]); o = int'(lfsr[5:4]) * 'h10;
      if (k % 23 == 0)
        step(lfsr[0], 1'b1, 1'b0, A(t, 'h10), int'(lfsr) & 'hFFF, "R2 mixed");
      else if (k % 31 == 0)
        step(lfsr[0], 1'b1, 1'b0, A(t, 'h00), 'hFFF0 | int'(lfsr[3:0]), "R4 mixed");
      else
        step(lfsr[0] | lfsr[7], 1'b0, 1'b1, A(t, o), 0, "R3 mixed read");
    end
    step(1'b0, 1'b0, 1'b0, 0, 0, "R5");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule